// File: doc/BRIEF.md
# Load-Use and Branch Interlock for a Six-Stage Integer Pipeline

This block is the hazard controller of an in-order integer pipeline whose stages run fetch, decode, execute, first memory, second memory and writeback. Each cycle it looks at the source registers of the instruction in decode and at the destination registers of the instructions in execute and the two memory stages. From these it decides whether decode must wait, whether execute receives an empty slot, and where each operand of the next instruction to enter execute is taken from. A load's data exists only at the end of the second memory stage. A consumer placed directly behind a load therefore waits two cycles, one placed a single instruction later waits one cycle, and one placed further back waits none.

Results that do not come from loads are forwarded at once. When several stages are about to write the register being read, the youngest of them wins. A branch that execute resolves as taken kills the two younger instructions in fetch and decode. The flush then costs two bubbles. A branch that is not taken passes with no penalty.

The stall, bubble and flush outputs are combinational in the current cycle's inputs. The operand-source codes are registered and describe the instruction that occupies execute, so the datapath applies them directly to its operand multiplexers.

Top module: `pipe_interlock`

## Requirements
- R1: When decode is valid and an enabled source register equals the destination of a valid, writing load in execute, `stall_fd` and `bubble_ex` are 1 in that cycle, unless a taken branch is present.
- R2: When the youngest matching producer of an enabled source is a load in the first memory stage, `stall_fd` is 1 for that cycle.
- R3: A load in the second memory stage never causes a stall. A consumer that advances while it is the youngest match sees code 2'b11 on its `ex_fwd` output in the following cycle.
- R4: Used as a real pipeline, a consumer of a load is held for 2, 1 or 0 cycles when 0, 1 or 2 instructions separate it from the load. It then receives code 2'b11.
- R5: Non-load producers never stall. The registered code is 2'b01 for the execute stage, 2'b10 for the first memory stage and 2'b11 for the second memory stage, with the youngest match taking priority, including over an older load.
- R6: When `ex_br_taken` is 1, `flush_fd` and `bubble_ex` are 1 and `stall_fd` is 0, even if a load hazard is present.
- R7: When `ex_br_taken` is 0, `flush_fd` is 0.
- R8: The operand codes on `ex_fwd_a`/`ex_fwd_b` update one clock after decode advances. After a cycle with `bubble_ex` = 1 both codes are 2'b00 (register file).
- R9: A source whose enable is 0, an invalid decode slot, and a producer with its valid or write-enable at 0 never match. No match gives code 2'b00 and no stall.
- R10: A clock edge with `rst` = 1 sets both operand codes to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode slot holds an instruction |
| id_rs1_en | input | 1 | First source operand is read |
| id_rs1 | input | REG_AW | First source register number |
| id_rs2_en | input | 1 | Second source operand is read |
| id_rs2 | input | REG_AW | Second source register number |
| ex_valid | input | 1 | Execute holds an instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_rd | input | REG_AW | Execute destination register |
| m1_valid | input | 1 | First memory stage holds an instruction |
| m1_wen | input | 1 | First memory stage instruction writes a register |
| m1_load | input | 1 | First memory stage instruction is a load |
| m1_rd | input | REG_AW | First memory stage destination register |
| m2_valid | input | 1 | Second memory stage holds an instruction |
| m2_wen | input | 1 | Second memory stage instruction writes a register |
| m2_rd | input | REG_AW | Second memory stage destination register |
| ex_br_taken | input | 1 | Branch in execute resolved as taken |
| stall_fd | output | 1 | Hold PC and the fetch/decode registers |
| bubble_ex | output | 1 | Load a no-op into execute next edge |
| flush_fd | output | 1 | Kill the fetch and decode instructions |
| ex_fwd_a | output | 2 | Source select for first operand of execute instruction |
| ex_fwd_b | output | 2 | Source select for second operand of execute instruction |

## Verification
Every cycle the checker ties the combinational controls to the stage inputs. It checks that a load match in execute always stalls, that a taken branch always flushes without stalling, that flush never appears without a taken branch, and that the absence of loads in execute and the first memory stage means no stall. It also confirms that a bubble clears the registered codes and that an advancing consumer of a sole second-stage producer gets code 11. The stall count of 2, 1 or 0 for each load distance can only be shown by the bench, which shifts stage contents as a pipeline would. The same holds for youngest-producer priority over an older load and for the masking of disabled operands.

// File: rtl/pipe_interlock_pkg.sv
package pipe_interlock_pkg;

    // Default register-number width (32 architectural registers).
    localparam int DEF_REG_AW = 5;

    // Number of source operands examined in decode.
    localparam int NSRC = 2;

    // Producer stages that can forward: index 0 = execute (youngest),
    // 1 = first memory stage, 2 = second memory stage (oldest).
    localparam int NPROD = 3;

    // Index of the first producer stage at which load data exists.
    localparam int LOAD_READY_IDX = 2;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        FWD_RF = 2'b00,
        FWD_EX = 2'b01,
        FWD_M1 = 2'b10,
        FWD_M2 = 2'b11
    } fwd_sel_e;

    // Producer stage index to its forwarding code.
    function automatic fwd_sel_e stage_code(input int idx);
        case (idx)
            0:       return FWD_EX;
            1:       return FWD_M1;
            default: return FWD_M2;
        endcase
    endfunction

    // A load's value cannot yet be forwarded from this stage.
    function automatic logic load_not_ready(input int idx, input logic is_load);
        return is_load && (idx < LOAD_READY_IDX);
    endfunction

endpackage

// File: rtl/pipe_interlock_src.sv
module pipe_interlock_src
    import pipe_interlock_pkg::*;
#(
    parameter int REG_AW = DEF_REG_AW
) (
    input  logic                         src_en_i,
    input  logic [REG_AW-1:0]            src_reg_i,
    input  logic [NPROD-1:0]             prod_wr_i,
    input  logic [NPROD-1:0]             prod_load_i,
    input  logic [NPROD-1:0][REG_AW-1:0] prod_rd_i,
    output fwd_sel_e                     sel_o,
    output logic                         hold_o
);

    logic [NPROD-1:0] hit;

    generate
        for (genvar p = 0; p < NPROD; p++) begin : g_cmp
            assign hit[p] = src_en_i && prod_wr_i[p] && (prod_rd_i[p] == src_reg_i);
        end
    endgenerate

    // Walk from oldest to youngest so the youngest match overrides.
    always_comb begin
        sel_o  = FWD_RF;
        hold_o = 1'b0;
        for (int p = NPROD - 1; p >= 0; p--) begin
            if (hit[p]) begin
                sel_o  = stage_code(p);
                hold_o = load_not_ready(p, prod_load_i[p]);
            end
        end
    end

endmodule

// File: rtl/pipe_interlock_ctrl.sv
module pipe_interlock_ctrl
    import pipe_interlock_pkg::*;
(
    input  logic            br_taken_i,
    input  logic [NSRC-1:0] hold_i,
    output logic            stall_o,
    output logic            bubble_o,
    output logic            flush_o
);

    // A flush kills decode, so any hazard it carries no longer matters.
    always_comb begin
        flush_o  = br_taken_i;
        stall_o  = !br_taken_i && (|hold_i);
        bubble_o = flush_o || stall_o;
    end

endmodule

// File: rtl/pipe_interlock_fwdreg.sv
module pipe_interlock_fwdreg
    import pipe_interlock_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       advance_i,
    input  logic [NSRC-1:0][SEL_W-1:0] sel_i,
    output logic [NSRC-1:0][SEL_W-1:0] sel_q
);

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    sel_q[s] <= FWD_RF;
                end else if (advance_i) begin
                    sel_q[s] <= sel_i[s];
                end else begin
                    sel_q[s] <= FWD_RF;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
    import pipe_interlock_pkg::*;
#(
    parameter int REG_AW = DEF_REG_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              id_valid,
    input  logic              id_rs1_en,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic              id_rs2_en,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              ex_valid,
    input  logic              ex_wen,
    input  logic              ex_load,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              m1_valid,
    input  logic              m1_wen,
    input  logic              m1_load,
    input  logic [REG_AW-1:0] m1_rd,
    input  logic              m2_valid,
    input  logic              m2_wen,
    input  logic [REG_AW-1:0] m2_rd,
    input  logic              ex_br_taken,
    output logic              stall_fd,
    output logic              bubble_ex,
    output logic              flush_fd,
    output logic [SEL_W-1:0]  ex_fwd_a,
    output logic [SEL_W-1:0]  ex_fwd_b
);

    logic [NPROD-1:0]             prod_wr;
    logic [NPROD-1:0]             prod_load;
    logic [NPROD-1:0][REG_AW-1:0] prod_rd;

    logic [NSRC-1:0]              src_en;
    logic [NSRC-1:0][REG_AW-1:0]  src_reg;
    logic [NSRC-1:0][SEL_W-1:0]   src_sel;
    logic [NSRC-1:0]              src_hold;
    logic [NSRC-1:0][SEL_W-1:0]   fwd_q;

    // A result in the second memory stage is always forwardable, so no
    // load flag is needed there.
    assign prod_wr   = {m2_valid & m2_wen, m1_valid & m1_wen, ex_valid & ex_wen};
    assign prod_load = {1'b0, m1_load, ex_load};
    assign prod_rd   = {m2_rd, m1_rd, ex_rd};

    assign src_en  = {id_valid & id_rs2_en, id_valid & id_rs1_en};
    assign src_reg = {id_rs2, id_rs1};

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            fwd_sel_e sel_e;
            pipe_interlock_src #(.REG_AW(REG_AW)) u_src (
                .src_en_i    (src_en[s]),
                .src_reg_i   (src_reg[s]),
                .prod_wr_i   (prod_wr),
                .prod_load_i (prod_load),
                .prod_rd_i   (prod_rd),
                .sel_o       (sel_e),
                .hold_o      (src_hold[s])
            );
            assign src_sel[s] = sel_e;
        end
    endgenerate

    pipe_interlock_ctrl u_ctrl (
        .br_taken_i (ex_br_taken),
        .hold_i     (src_hold),
        .stall_o    (stall_fd),
        .bubble_o   (bubble_ex),
        .flush_o    (flush_fd)
    );

    pipe_interlock_fwdreg u_fwd (
        .clk       (clk),
        .rst       (rst),
        .advance_i (!bubble_ex),
        .sel_i     (src_sel),
        .sel_q     (fwd_q)
    );

    assign ex_fwd_a = fwd_q[0];
    assign ex_fwd_b = fwd_q[1];

endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              id_valid,
    input logic              id_rs1_en,
    input logic [REG_AW-1:0] id_rs1,
    input logic              id_rs2_en,
    input logic [REG_AW-1:0] id_rs2,
    input logic              ex_valid,
    input logic              ex_wen,
    input logic              ex_load,
    input logic [REG_AW-1:0] ex_rd,
    input logic              m1_valid,
    input logic              m1_wen,
    input logic              m1_load,
    input logic [REG_AW-1:0] m1_rd,
    input logic              m2_valid,
    input logic              m2_wen,
    input logic [REG_AW-1:0] m2_rd,
    input logic              ex_br_taken,
    input logic              stall_fd,
    input logic              bubble_ex,
    input logic              flush_fd,
    input logic [1:0]        ex_fwd_a,
    input logic [1:0]        ex_fwd_b
);

    logic ex_ld_hit_a;
    logic m2_only_a;
    logic loads_idle;

    assign ex_ld_hit_a = id_valid && id_rs1_en && ex_valid && ex_wen && ex_load
                         && (ex_rd == id_rs1);
    assign m2_only_a   = id_valid && id_rs1_en && m2_valid && m2_wen && (m2_rd == id_rs1)
                         && !(ex_valid && ex_wen && ex_rd == id_rs1)
                         && !(m1_valid && m1_wen && m1_rd == id_rs1);
    assign loads_idle  = !(ex_valid && ex_load) && !(m1_valid && m1_load);

    assert_load_ex_stalls_R1: assert property (@(posedge clk) disable iff (rst)
        (ex_ld_hit_a && !ex_br_taken) |-> (stall_fd && bubble_ex));

    assert_taken_flushes_R6: assert property (@(posedge clk) disable iff (rst)
        ex_br_taken |-> (flush_fd && bubble_ex && !stall_fd));

    assert_no_spurious_flush_R7: assert property (@(posedge clk) disable iff (rst)
        !ex_br_taken |-> !flush_fd);

    assert_bubble_clears_codes_R8: assert property (@(posedge clk) disable iff (rst)
        bubble_ex |=> (ex_fwd_a == 2'b00 && ex_fwd_b == 2'b00));

    assert_m2_forward_R3: assert property (@(posedge clk) disable iff (rst)
        (m2_only_a && !bubble_ex) |=> (ex_fwd_a == 2'b11));

    assert_nonload_nostall_R5: assert property (@(posedge clk) disable iff (rst)
        loads_idle |-> !stall_fd);

    assert_reset_codes_R10: assert property (@(posedge clk)
        rst |=> (ex_fwd_a == 2'b00 && ex_fwd_b == 2'b00));

endmodule

bind pipe_interlock pipe_interlock_chk #(.REG_AW(REG_AW)) u_chk (
    .clk(clk), .rst(rst),
    .id_valid(id_valid), .id_rs1_en(id_rs1_en), .id_rs1(id_rs1),
    .id_rs2_en(id_rs2_en), .id_rs2(id_rs2),
    .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_load(ex_load), .ex_rd(ex_rd),
    .m1_valid(m1_valid), .m1_wen(m1_wen), .m1_load(m1_load), .m1_rd(m1_rd),
    .m2_valid(m2_valid), .m2_wen(m2_wen), .m2_rd(m2_rd),
    .ex_br_taken(ex_br_taken),
    .stall_fd(stall_fd), .bubble_ex(bubble_ex), .flush_fd(flush_fd),
    .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b)
);

// File: tb/pipe_interlock_bench.sv
module pipe_interlock_bench;

    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic id_valid, id_rs1_en, id_rs2_en;
    logic [RW-1:0] id_rs1, id_rs2;
    logic ex_valid, ex_wen, ex_load;
    logic [RW-1:0] ex_rd;
    logic m1_valid, m1_wen, m1_load;
    logic [RW-1:0] m1_rd;
    logic m2_valid, m2_wen;
    logic [RW-1:0] m2_rd;
    logic ex_br_taken;
    logic stall_fd, bubble_ex, flush_fd;
    logic [1:0] ex_fwd_a, ex_fwd_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pipe_interlock #(.REG_AW(RW)) u_pipe_interlock (
        .clk(clk), .rst(rst),
        .id_valid(id_valid), .id_rs1_en(id_rs1_en), .id_rs1(id_rs1),
        .id_rs2_en(id_rs2_en), .id_rs2(id_rs2),
        .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_load(ex_load), .ex_rd(ex_rd),
        .m1_valid(m1_valid), .m1_wen(m1_wen), .m1_load(m1_load), .m1_rd(m1_rd),
        .m2_valid(m2_valid), .m2_wen(m2_wen), .m2_rd(m2_rd),
        .ex_br_taken(ex_br_taken),
        .stall_fd(stall_fd), .bubble_ex(bubble_ex), .flush_fd(flush_fd),
        .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_all();
        id_valid = 0; id_rs1_en = 0; id_rs2_en = 0; id_rs1 = '0; id_rs2 = '0;
        ex_valid = 0; ex_wen = 0; ex_load = 0; ex_rd = '0;
        m1_valid = 0; m1_wen = 0; m1_load = 0; m1_rd = '0;
        m2_valid = 0; m2_wen = 0; m2_rd = '0;
        ex_br_taken = 0;
    endtask

    // Advance past the next rising edge; new inputs go in just after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_ex(input logic ld, input logic [RW-1:0] rd);
        ex_valid = 1; ex_wen = 1; ex_load = ld; ex_rd = rd;
    endtask
    task automatic set_m1(input logic ld, input logic [RW-1:0] rd);
        m1_valid = 1; m1_wen = 1; m1_load = ld; m1_rd = rd;
    endtask
    task automatic set_m2(input logic [RW-1:0] rd);
        m2_valid = 1; m2_wen = 1; m2_rd = rd;
    endtask
    task automatic set_id(input logic [RW-1:0] a, input logic ea,
                          input logic [RW-1:0] b, input logic eb);
        id_valid = 1; id_rs1 = a; id_rs1_en = ea; id_rs2 = b; id_rs2_en = eb;
    endtask

    task automatic t_reset();
        idle_all();
        rst = 1;
        tick();
        tick();
        chk("R10 reset fwd_a", ex_fwd_a, 0);
        chk("R10 reset fwd_b", ex_fwd_b, 0);
        chk("R9 idle no stall", stall_fd, 0);
        rst = 0;
        tick();
    endtask

    task automatic t_load_in_ex();
        idle_all();
        set_ex(1, 5'd3);
        set_id(5'd9, 1, 5'd3, 1);
        #1;
        chk("R1 stall on rs2", stall_fd, 1);
        chk("R1 bubble", bubble_ex, 1);
        chk("R7 no flush", flush_fd, 0);
        tick();
        chk("R8 bubble code a", ex_fwd_a, 0);
        chk("R8 bubble code b", ex_fwd_b, 0);
    endtask

    task automatic t_load_in_m1();
        idle_all();
        set_m1(1, 5'd11);
        set_id(5'd11, 1, 5'd0, 0);
        #1;
        chk("R2 stall m1 load", stall_fd, 1);
        chk("R2 bubble m1 load", bubble_ex, 1);
        tick();
    endtask

    task automatic t_load_in_m2();
        idle_all();
        set_m2(5'd12);
        set_id(5'd12, 1, 5'd0, 0);
        #1;
        chk("R3 no stall m2", stall_fd, 0);
        tick();
        chk("R3 fwd_a from m2", ex_fwd_a, 3);
    endtask

    task automatic t_priority();
        idle_all();
        set_ex(0, 5'd5); set_m1(0, 5'd5); set_m2(5'd5);
        set_id(5'd5, 1, 5'd0, 0);
        #1;
        chk("R5 no stall alu", stall_fd, 0);
        tick();
        chk("R5 youngest is ex", ex_fwd_a, 1);
        ex_valid = 0;
        #1;
        tick();
        chk("R5 next is m1", ex_fwd_a, 2);
        // younger non-load in ex shadows an older load in m1
        idle_all();
        set_ex(0, 5'd8); set_m1(1, 5'd8);
        set_id(5'd8, 1, 5'd0, 0);
        #1;
        chk("R5 younger alu over load", stall_fd, 0);
        tick();
        chk("R5 code ex over load", ex_fwd_a, 1);
    endtask

    task automatic t_two_operands();
        idle_all();
        set_m1(0, 5'd14); set_m2(5'd15);
        set_id(5'd14, 1, 5'd15, 1);
        tick();
        chk("R5 operand a m1", ex_fwd_a, 2);
        chk("R5 operand b m2", ex_fwd_b, 3);
        idle_all();
        set_id(5'd14, 1, 5'd15, 1);
        tick();
        chk("R9 no producer -> rf a", ex_fwd_a, 0);
        chk("R9 no producer -> rf b", ex_fwd_b, 0);
    endtask

    task automatic t_masking();
        idle_all();
        set_ex(1, 5'd4);
        set_id(5'd4, 0, 5'd0, 0);
        #1;
        chk("R9 disabled operand", stall_fd, 0);
        id_rs1_en = 1; id_valid = 0;
        #1;
        chk("R9 invalid decode", stall_fd, 0);
        id_valid = 1; ex_wen = 0;
        #1;
        chk("R9 non-writing producer", stall_fd, 0);
        ex_wen = 1; ex_valid = 0;
        #1;
        chk("R9 invalid producer", stall_fd, 0);
        tick();
        chk("R9 code rf", ex_fwd_a, 0);
    endtask

    task automatic t_branch();
        idle_all();
        set_ex(1, 5'd6);
        set_id(5'd6, 1, 5'd0, 0);
        ex_br_taken = 1;
        #1;
        chk("R6 flush", flush_fd, 1);
        chk("R6 flush beats stall", stall_fd, 0);
        chk("R6 bubble", bubble_ex, 1);
        tick();
        chk("R8 code after flush", ex_fwd_a, 0);
        idle_all();
        set_ex(0, 5'd1);
        set_id(5'd2, 1, 5'd0, 0);
        #1;
        chk("R7 not taken no flush", flush_fd, 0);
        chk("R7 not taken no bubble", bubble_ex, 0);
        tick();
    endtask

    // Consumer of r7 enters decode with gap instructions after the load.
    task automatic t_sequence(input int gap);
        logic v [3];
        logic l [3];
        logic [RW-1:0] r [3];
        int stalls = 0;
        bit done = 0;
        for (int i = 0; i < 3; i++) begin v[i] = 0; l[i] = 0; r[i] = '0; end
        v[gap] = 1; l[gap] = 1; r[gap] = 5'd7;
        for (int i = 0; i < gap; i++) begin v[i] = 1; r[i] = 5'd20 + 5'(i); end
        idle_all();
        set_id(5'd7, 1, 5'd0, 0);
        for (int k = 0; k < 5 && !done; k++) begin
            ex_valid = v[0]; ex_wen = v[0]; ex_load = l[0]; ex_rd = r[0];
            m1_valid = v[1]; m1_wen = v[1]; m1_load = l[1]; m1_rd = r[1];
            m2_valid = v[2]; m2_wen = v[2]; m2_rd = r[2];
            #1;
            if (stall_fd) begin
                stalls++;
                tick();
                v[2] = v[1]; l[2] = l[1]; r[2] = r[1];
                v[1] = v[0]; l[1] = l[0]; r[1] = r[0];
                v[0] = 0;    l[0] = 0;    r[0] = '0;
            end else begin
                done = 1;
                tick();
            end
        end
        chk($sformatf("R4 stalls with gap %0d", gap), stalls, 2 - gap);
        chk($sformatf("R4 bypass code gap %0d", gap), ex_fwd_a, 3);
    endtask

    initial begin
        #150000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle_all();
        t_reset();
        t_load_in_ex();
        t_load_in_m1();
        t_load_in_m2();
        t_priority();
        t_two_operands();
        t_masking();
        t_branch();
        for (int g = 0; g < 3; g++) t_sequence(g);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule